// File: doc/BRIEF.md
# Dual-Bank Asynchronous-Bus DRAM Controller

This block sits between a 16-bit asynchronous CPU bus and two 16-bit DRAM banks. Each bank has one row strobe, a lower and an upper byte-lane column strobe, and its own write enable. The controller runs on its own clock, separate from the CPU clock. It passes the CPU address strobe and the DRAM chip select through two-stage synchronisers. It then steps one access through a chain of short states. The first states put the row half of the address on an 11-bit multiplexed bus, and the later ones put the column half there. The access ends by driving an active-low acknowledge back to the CPU.

A free-running interval counter asks for a CAS-before-RAS refresh of both banks. The state machine takes the request from idle, acknowledges it, and runs a four-state refresh. Every access and every refresh ends in a precharge state of fixed length. In that state all strobes are inactive. The bank is chosen by an input decoded upstream: low selects bank A, high selects bank B.

States and transitions: `ST_IDLE` goes to `ST_REF1` when a refresh is pending. Otherwise it goes to `ST_ROW` when the synchronised chip select and address strobe are both low. An access then runs `ST_ROW` → `ST_RAS` → `ST_COL` → `ST_CAS` → `ST_ACK`. `ST_ACK` waits until the synchronised address strobe is high, then moves to `ST_PRE`. A refresh runs `ST_REF1` → `ST_REF2` → `ST_REF3` → `ST_REF4` → `ST_PRE`. `ST_PRE` returns to `ST_IDLE` after `PRE_CYCLES` clocks.

Top module: `dram_ctl_dual`

## Requirements
- R1: In `ST_ROW` the 11-bit DRAM address takes CPU address bits [11:1]. In `ST_COL` it takes bits [22:12]. It holds its value in all other states.
- R2: During an access, only the bank latched at the start (select 0 = A, 1 = B) drives its row strobe low from `ST_RAS`, its write enable from `ST_COL`, and its column strobes from `ST_CAS`. The other bank keeps all of its strobes high.
- R3: In the selected bank, the lower-lane column strobe copies the lower data strobe and the upper-lane column strobe copies the upper data strobe. Both are active low. Write enable goes low for a write (R/W = 0) and stays high for a read (R/W = 1).
- R4: Each access state lasts one clock. The acknowledge output is low only in `ST_ACK`. It stays low until the synchronised address strobe reads high.
- R5: The refresh counter raises its request on the edge where it has counted `REFRESH_INTERVAL`, then restarts from zero. The acknowledge clears the request. A new request raised on the same edge as an acknowledge survives.
- R6: Refresh runs as follows. `ST_REF1` pulses the acknowledge, drives all four column strobes low, and forces both write enables high. `ST_REF2` adds both row strobes low. `ST_REF3` raises the column strobes while both row strobes stay low. `ST_REF4` raises everything.
- R7: The address strobe and chip select each pass through two registers that reset high. An access starts only when both are low, so a strobe seen with the chip select high starts nothing. `ST_ROW` is entered on the third rising edge after both inputs fall.
- R8: In `ST_IDLE`, a pending refresh request takes priority over a pending access.
- R9: `ST_PRE` holds every row strobe, column strobe, write enable and the acknowledge high for `PRE_CYCLES` clocks before `ST_IDLE`.
- R10: While the active-low reset is held, all strobes, write enables and the acknowledge are high, the DRAM address is zero, and no refresh is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, independent of the CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 22 | CPU address bits [22:1] |
| cpu_as_n | input | 1 | CPU address strobe, active low, asynchronous |
| dram_cs_n | input | 1 | DRAM region select, active low, asynchronous |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_uds_n | input | 1 | Upper data strobe, active low |
| cpu_lds_n | input | 1 | Lower data strobe, active low |
| bank_b_sel | input | 1 | 0 = bank A, 1 = bank B |
| dtack_n | output | 1 | Access acknowledge to the CPU, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| ras_a_n | output | 1 | Bank A row strobe |
| ras_b_n | output | 1 | Bank B row strobe |
| cas_a_lo_n | output | 1 | Bank A lower-lane column strobe |
| cas_a_hi_n | output | 1 | Bank A upper-lane column strobe |
| cas_b_lo_n | output | 1 | Bank B lower-lane column strobe |
| cas_b_hi_n | output | 1 | Bank B upper-lane column strobe |
| we_a_n | output | 1 | Bank A write enable |
| we_b_n | output | 1 | Bank B write enable |

## Verification
The bench builds the controller with `REFRESH_INTERVAL` = 40 and `PRE_CYCLES` = 3. With these values refreshes come often enough to land while an access is arriving, during a held acknowledge, and on the edge where the previous request is being acknowledged. A three-clock precharge makes its length visible. One access holds the address strobe low for longer than several refresh periods. This shows that the request is held and not lost, and that refresh waits for idle.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;

    localparam int BANKS = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW,
        ST_RAS,
        ST_COL,
        ST_CAS,
        ST_ACK,
        ST_PRE,
        ST_REF1,
        ST_REF2,
        ST_REF3,
        ST_REF4
    } seq_state_t;

endpackage

// File: rtl/dram_sync.sv
module dram_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= '1;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[i] <= '1;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int INTERVAL = 781
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_ack,
    output logic ref_req
);

    localparam int CW = $clog2(INTERVAL + 1);

    logic [CW-1:0] cnt;
    logic          hit;

    assign hit = (cnt == CW'(INTERVAL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            ref_req <= 1'b0;
        end else begin
            if (hit) cnt <= '0;
            else     cnt <= cnt + 1'b1;
            // a fresh request outranks the clear of the previous one
            if (hit)          ref_req <= 1'b1;
            else if (ref_ack) ref_req <= 1'b0;
        end
    end

    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_ack) |=> ref_req);

    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_ack && !hit) |=> !ref_req);

endmodule

// File: rtl/dram_sequencer.sv
module dram_sequencer
    import dram_ctl_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int ROW_LSB    = 1,
    parameter int PRE_CYCLES = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                as_s_n,
    input  logic                                cs_s_n,
    input  logic                                ref_req,
    output logic                                ref_ack,
    input  logic [ROW_LSB+2*ADDR_W-1:ROW_LSB]   cpu_addr,
    input  logic                                cpu_rw,
    input  logic                                uds_n,
    input  logic                                lds_n,
    input  logic                                bank_b_sel,
    output logic                                dtack_n,
    output logic [ADDR_W-1:0]                   dram_addr,
    output logic [BANKS-1:0]                    ras_n,
    output logic [BANKS-1:0]                    cas_lo_n,
    output logic [BANKS-1:0]                    cas_hi_n,
    output logic [BANKS-1:0]                    we_n
);

    localparam int PW = (PRE_CYCLES > 1) ? $clog2(PRE_CYCLES) : 1;

    seq_state_t     state, nxt;
    logic [PW-1:0]  pre_cnt;
    logic           bank_q;
    logic [ADDR_W-1:0] row_a, col_a;

    assign row_a = cpu_addr[ROW_LSB +: ADDR_W];
    assign col_a = cpu_addr[ROW_LSB+ADDR_W +: ADDR_W];

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (ref_req)                 nxt = ST_REF1;
                else if (!cs_s_n && !as_s_n) nxt = ST_ROW;
            end
            ST_ROW:  nxt = ST_RAS;
            ST_RAS:  nxt = ST_COL;
            ST_COL:  nxt = ST_CAS;
            ST_CAS:  nxt = ST_ACK;
            ST_ACK:  if (as_s_n) nxt = ST_PRE;
            ST_PRE:  if (pre_cnt == '0) nxt = ST_IDLE;
            ST_REF1: nxt = ST_REF2;
            ST_REF2: nxt = ST_REF3;
            ST_REF3: nxt = ST_REF4;
            ST_REF4: nxt = ST_PRE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register, precharge timer, bank latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pre_cnt <= '0;
            bank_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt == ST_PRE && state != ST_PRE) pre_cnt <= PW'(PRE_CYCLES - 1);
            else if (state == ST_PRE)             pre_cnt <= pre_cnt - 1'b1;
            if (state == ST_IDLE && nxt == ST_ROW) bank_q <= bank_b_sel;
        end
    end

    // registered outputs, decoded from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_n     <= '1;
            cas_lo_n  <= '1;
            cas_hi_n  <= '1;
            we_n      <= '1;
            dtack_n   <= 1'b1;
            ref_ack   <= 1'b0;
            dram_addr <= '0;
        end else begin
            ras_n    <= '1;
            cas_lo_n <= '1;
            cas_hi_n <= '1;
            we_n     <= '1;
            dtack_n  <= 1'b1;
            ref_ack  <= 1'b0;
            unique case (nxt)
                ST_ROW: dram_addr <= row_a;
                ST_RAS: ras_n[bank_q] <= 1'b0;
                ST_COL: begin
                    dram_addr     <= col_a;
                    ras_n[bank_q] <= 1'b0;
                    we_n[bank_q]  <= cpu_rw;
                end
                ST_CAS, ST_ACK: begin
                    ras_n[bank_q]    <= 1'b0;
                    we_n[bank_q]     <= cpu_rw;
                    cas_lo_n[bank_q] <= lds_n;
                    cas_hi_n[bank_q] <= uds_n;
                    if (nxt == ST_ACK) dtack_n <= 1'b0;
                end
                ST_REF1: begin
                    cas_lo_n <= '0;
                    cas_hi_n <= '0;
                    ref_ack  <= 1'b1;
                end
                ST_REF2: begin
                    cas_lo_n <= '0;
                    cas_hi_n <= '0;
                    ras_n    <= '0;
                end
                ST_REF3: ras_n <= '0;
                default: ;
            endcase
        end
    end

    a_r2_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
        !dtack_n |-> (ras_n[0] != ras_n[1]));

    a_r4_dtack_after_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n) |-> ($past(ras_n) != '1));

    a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |=> !ref_ack);

    a_r8_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ref_req) |=> (state == ST_REF1));

    a_r9_ras_a_rest: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n[0]) |=> ras_n[0]);

    a_r9_ras_b_rest: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n[1]) |=> ras_n[1]);

endmodule

// File: rtl/dram_ctl_dual.sv
module dram_ctl_dual
    import dram_ctl_pkg::*;
#(
    parameter int ADDR_W           = 11,
    parameter int ROW_LSB          = 1,
    parameter int REFRESH_INTERVAL = 781,
    parameter int PRE_CYCLES       = 2,
    parameter int SYNC_STAGES      = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ROW_LSB+2*ADDR_W-1:ROW_LSB] cpu_addr,
    input  logic                              cpu_as_n,
    input  logic                              dram_cs_n,
    input  logic                              cpu_rw,
    input  logic                              cpu_uds_n,
    input  logic                              cpu_lds_n,
    input  logic                              bank_b_sel,
    output logic                              dtack_n,
    output logic [ADDR_W-1:0]                 dram_addr,
    output logic                              ras_a_n,
    output logic                              ras_b_n,
    output logic                              cas_a_lo_n,
    output logic                              cas_a_hi_n,
    output logic                              cas_b_lo_n,
    output logic                              cas_b_hi_n,
    output logic                              we_a_n,
    output logic                              we_b_n
);

    logic [1:0]       strobes_s;
    logic             ref_req, ref_ack;
    logic [BANKS-1:0] ras_n, cas_lo_n, cas_hi_n, we_n;

    dram_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({dram_cs_n, cpu_as_n}),
        .q     (strobes_s)
    );

    dram_refresh_timer #(.INTERVAL(REFRESH_INTERVAL)) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_ack (ref_ack),
        .ref_req (ref_req)
    );

    dram_sequencer #(
        .ADDR_W     (ADDR_W),
        .ROW_LSB    (ROW_LSB),
        .PRE_CYCLES (PRE_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .as_s_n     (strobes_s[0]),
        .cs_s_n     (strobes_s[1]),
        .ref_req    (ref_req),
        .ref_ack    (ref_ack),
        .cpu_addr   (cpu_addr),
        .cpu_rw     (cpu_rw),
        .uds_n      (cpu_uds_n),
        .lds_n      (cpu_lds_n),
        .bank_b_sel (bank_b_sel),
        .dtack_n    (dtack_n),
        .dram_addr  (dram_addr),
        .ras_n      (ras_n),
        .cas_lo_n   (cas_lo_n),
        .cas_hi_n   (cas_hi_n),
        .we_n       (we_n)
    );

    assign ras_a_n    = ras_n[0];
    assign ras_b_n    = ras_n[1];
    assign cas_a_lo_n = cas_lo_n[0];
    assign cas_a_hi_n = cas_hi_n[0];
    assign cas_b_lo_n = cas_lo_n[1];
    assign cas_b_hi_n = cas_hi_n[1];
    assign we_a_n     = we_n[0];
    assign we_b_n     = we_n[1];

endmodule

// File: tb/dram_ctl_dual_bench.sv
module dram_ctl_dual_bench;

    localparam int CLK_PERIOD = 10;
    localparam int INTERVAL   = 40;
    localparam int PRE        = 3;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [22:1] cpu_addr = '0;
    logic        cpu_as_n = 1'b1, dram_cs_n = 1'b1, cpu_rw = 1'b1;
    logic        cpu_uds_n = 1'b1, cpu_lds_n = 1'b1, bank_b_sel = 1'b0;
    logic        dtack_n;
    logic [10:0] dram_addr;
    logic        ras_a_n, ras_b_n, cas_a_lo_n, cas_a_hi_n, cas_b_lo_n, cas_b_hi_n, we_a_n, we_b_n;

    int tests = 0, fails = 0, cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_ctl_dual #(.REFRESH_INTERVAL(INTERVAL), .PRE_CYCLES(PRE)) u_dram_ctl_dual (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_as_n(cpu_as_n),
        .dram_cs_n(dram_cs_n), .cpu_rw(cpu_rw), .cpu_uds_n(cpu_uds_n),
        .cpu_lds_n(cpu_lds_n), .bank_b_sel(bank_b_sel), .dtack_n(dtack_n),
        .dram_addr(dram_addr), .ras_a_n(ras_a_n), .ras_b_n(ras_b_n),
        .cas_a_lo_n(cas_a_lo_n), .cas_a_hi_n(cas_a_hi_n), .cas_b_lo_n(cas_b_lo_n),
        .cas_b_hi_n(cas_b_hi_n), .we_a_n(we_a_n), .we_b_n(we_b_n)
    );

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cycles, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // phase: 0 idle, 1 row, 2 ras, 3 col, 4 cas, 5 ack, 6 rest, 7..10 refresh steps
    int         m_ph, m_rest, m_cnt;
    bit         m_req, m_as1, m_as2, m_cs1, m_cs2, m_bank;
    bit [1:0]   e_ras, e_clo, e_chi, e_we;
    bit         e_dtack;
    bit [10:0]  e_addr;
    bit         model_on = 1'b0;

    always @(posedge clk) begin
        int  nph;
        bit  hit, ack_now;
        if (!rst_n) begin
            m_ph = 0; m_rest = 0; m_cnt = 0; m_req = 0;
            m_as1 = 1; m_as2 = 1; m_cs1 = 1; m_cs2 = 1; m_bank = 0;
            e_ras = 2'b11; e_clo = 2'b11; e_chi = 2'b11; e_we = 2'b11;
            e_dtack = 1; e_addr = '0;
        end else begin
            ack_now = (m_ph == 7);
            hit = (m_cnt == INTERVAL);
            case (m_ph)
                0: nph = m_req ? 7 : ((!m_cs2 && !m_as2) ? 1 : 0);
                5: nph = m_as2 ? 6 : 5;
                6: nph = (m_rest == 0) ? 0 : 6;
                10: nph = 6;
                default: nph = m_ph + 1;
            endcase
            if (nph == 6 && m_ph != 6) m_rest = PRE - 1;
            else if (m_ph == 6) m_rest = m_rest - 1;
            if (m_ph == 0 && nph == 1) m_bank = bank_b_sel;
            e_ras = 2'b11; e_clo = 2'b11; e_chi = 2'b11; e_we = 2'b11; e_dtack = 1;
            if (nph == 1) e_addr = cpu_addr[11:1];
            if (nph == 3) e_addr = cpu_addr[22:12];
            if (nph >= 2 && nph <= 5) e_ras[m_bank] = 0;
            if (nph >= 3 && nph <= 5) e_we[m_bank] = cpu_rw;
            if (nph == 4 || nph == 5) begin
                e_clo[m_bank] = cpu_lds_n;
                e_chi[m_bank] = cpu_uds_n;
            end
            if (nph == 5) e_dtack = 0;
            if (nph == 7 || nph == 8) begin e_clo = 2'b00; e_chi = 2'b00; end
            if (nph == 8 || nph == 9) e_ras = 2'b00;
            m_ph = nph;
            m_cnt = hit ? 0 : m_cnt + 1;
            if (hit) m_req = 1; else if (ack_now) m_req = 0;
            m_as2 = m_as1; m_as1 = cpu_as_n;
            m_cs2 = m_cs1; m_cs1 = dram_cs_n;
        end
    end

    always @(negedge clk) begin
        if (model_on && !done) begin
            check("R1 address", dram_addr, e_addr);
            check("R2 row strobes", {ras_b_n, ras_a_n}, e_ras);
            check("R3 lower column strobes", {cas_b_lo_n, cas_a_lo_n}, e_clo);
            check("R3 upper column strobes", {cas_b_hi_n, cas_a_hi_n}, e_chi);
            check("R3 write enables", {we_b_n, we_a_n}, e_we);
            check("R4 acknowledge", dtack_n, e_dtack);
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic access(bit [22:0] a, bit bank, bit rw, bit uds, bit lds, int hold);
        int waited = 0;
        @(negedge clk);
        cpu_addr = a[22:1]; bank_b_sel = bank; cpu_rw = rw;
        cpu_uds_n = uds; cpu_lds_n = lds;
        cpu_as_n = 1'b0; dram_cs_n = 1'b0;
        do begin
            @(negedge clk);
            waited++;
        end while (dtack_n && waited < 2000);
        check("R4 acknowledge reached", int'(dtack_n), 0);
        repeat (hold) @(negedge clk);
        cpu_as_n = 1'b1; dram_cs_n = 1'b1;
        cpu_uds_n = 1'b1; cpu_lds_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset values at the ports
        check("R10 reset acknowledge", dtack_n, 1);
        check("R10 reset row strobes", {ras_b_n, ras_a_n}, 3);
        check("R10 reset column strobes", {cas_b_hi_n, cas_b_lo_n, cas_a_hi_n, cas_a_lo_n}, 15);
        check("R10 reset write enables", {we_b_n, we_a_n}, 3);
        check("R10 reset address", dram_addr, 0);
        rst_n = 1'b1;
        model_on = 1'b1;

        // R7: strobe with chip select high starts nothing
        @(negedge clk);
        cpu_as_n = 1'b0;
        repeat (10) @(negedge clk);
        check("R7 no access without chip select", {ras_b_n, ras_a_n, dtack_n}, 7);
        cpu_as_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 R2 R3 R4: patterns across banks, lanes and directions
        access(23'h2A_5A5A, 1'b0, 1'b1, 1'b0, 1'b0, 0);
        access(23'h55_A5A4, 1'b1, 1'b0, 1'b0, 1'b1, 2);
        access(23'h7F_FFFE, 1'b0, 1'b0, 1'b1, 1'b0, 1);
        access(23'h00_0002, 1'b1, 1'b1, 1'b1, 1'b0, 5);
        access(23'h40_1000, 1'b1, 1'b0, 1'b0, 1'b0, 0);
        // R5 R8: long hold spans several refresh intervals
        access(23'h12_3456, 1'b0, 1'b0, 1'b0, 1'b0, 130);
        // R6 R9: idle stretch lets refreshes run alone
        repeat (200) @(negedge clk);
        // back-to-back accesses shifted in phase against the refresh counter
        for (int i = 0; i < 24; i++) begin
            access(23'((i * 23'h3_1337) ^ 23'h55_5554), 1'(i & 1), 1'((i >> 1) & 1),
                   1'((i % 3) == 1), 1'((i % 3) == 2), i % 4);
            repeat (i % 7) @(negedge clk);
        end
        repeat (50) @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule